// File: doc/BRIEF.md
# Configuration Length Count Monitor

This block decides when device configuration has finished. Once the init signal is high, it counts every configuration clock. At some point during the run, a strobe loads an expected length value taken from the configuration stream. The block raises its completion pulse only when two conditions hold in the same cycle: the configuration memory reports that it is full, and the running clock count equals the stored length exactly. The completion pulse starts the start-up sequence further down the chip.

The count starts at the very first clock after init rises, not at the end of any preamble. A stray leading clock therefore puts the count one step out of line with the data. When that happens, no completion occurs at the expected point. The counter keeps running, wraps through zero and meets the stored length a second time one full counter period later. In express mode the length is ignored, and completion follows directly from the memory-full flag. Driving init low clears the counter, the stored length and the completion state, which readies the block for a fresh configuration.

Top module: `cfg_len_monitor`

## Requirements
- R1: A high `lenLoad` at a clock edge stores `lenValue` as the expected length. A later load replaces an earlier one.
- R2: The count is the number of rising `cfgClk` edges sampled with `initReady` high. In counted mode, completion is detected at edge L+1 when the stored length is L and `memFull` is already high, and `startPulse` is high for the cycle after that edge.
- R3: In counted mode, completion needs `memFull` high and the count equal to the stored length in the same cycle. Either condition on its own never produces a pulse.
- R4: Suppose `memFull` rises after the count has passed L. No pulse follows until the `CNT_W`-bit counter wraps. The pulse then comes at edge L+1+2^CNT_W.
- R5: With `expressMode` = 1 (express), completion is detected at the first edge that samples `memFull` high, whatever length is stored.
- R6: While `initReady` is low, `startPulse` is 0, and the count, the stored length and the completion state are cleared. A new configuration after init goes low again therefore starts from a count of zero with no stored length.
- R7: `startPulse` lasts one cycle and occurs at most once per init-high period, even if `memFull` stays high.
- R8: A stored length of zero, including no load at all, never matches in counted mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration clock |
| initReady | input | 1 | High while configuration runs; low clears all state (asynchronous) |
| lenLoad | input | 1 | Strobe that stores `lenValue` as the expected length |
| lenValue | input | CNT_W | Expected length count from the configuration stream |
| memFull | input | 1 | Configuration memory full flag |
| expressMode | input | 1 | 0 = counted completion, 1 = express completion |
| startPulse | output | 1 | One-cycle completion pulse that starts the start-up sequence |

## Verification
Some properties are checked on every cycle. These are the one-cycle width of the pulse and the rule of a single pulse once completion is latched. Two more are that any counted-mode pulse follows a cycle with a full memory and an exact, nonzero match, and that the counter steps by one (wrapping) until completion. Properties on the exact cycle of completion need the bench's scenarios: early and late memory-full, loads that replace earlier ones, wrap-around recovery after a missed match, zero and missing lengths, and express mode. The same holds for the state-clearing effect of init, which is seen as correct timing in the configuration that follows.

// File: rtl/cfg_len_pkg.sv
`timescale 1ns/1ps
package cfg_len_pkg;

  typedef enum logic {
    MODE_COUNTED = 1'b0,
    MODE_EXPRESS = 1'b1
  } cfgMode_e;

  // control -> datapath
  typedef struct packed {
    logic cntAdvance;
    logic lenCapture;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic countMatch;
    logic lenIsZero;
  } dpFlags_t;

endpackage

// File: rtl/cfg_len_datapath.sv
`timescale 1ns/1ps
module cfg_len_datapath
  import cfg_len_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             clrN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] lenIn,
  output dpFlags_t         flags,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] lenQ
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  // clock counter, wraps modulo 2^CNT_W
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                 cntQ <= CNT_ZERO;
    else if (strobe.cntAdvance) cntQ <= cntQ + CNT_ONE;
  end

  // expected length register
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                 lenQ <= CNT_ZERO;
    else if (strobe.lenCapture) lenQ <= lenIn;
  end

  always_comb begin
    flags.countMatch = (cntQ == lenQ);
    flags.lenIsZero  = (lenQ == CNT_ZERO);
  end

endmodule

// File: rtl/cfg_len_control.sv
`timescale 1ns/1ps
module cfg_len_control
  import cfg_len_pkg::*;
(
  input  logic      clk,
  input  logic      clrN,
  input  logic      loadReq,
  input  logic      fullFlag,
  input  cfgMode_e  mode,
  input  dpFlags_t  flags,
  output dpStrobe_t strobe,
  output logic      doneLatch,
  output logic      pulseQ
);

  logic countedOk;
  logic completeNow;

  always_comb begin
    countedOk = flags.countMatch && !flags.lenIsZero;
    unique case (mode)
      MODE_EXPRESS: completeNow = fullFlag;
      default:      completeNow = fullFlag && countedOk;
    endcase
    strobe.cntAdvance = !doneLatch;
    strobe.lenCapture = loadReq;
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      doneLatch <= 1'b0;
      pulseQ    <= 1'b0;
    end else begin
      pulseQ <= completeNow && !doneLatch;
      if (completeNow) doneLatch <= 1'b1;
    end
  end

endmodule

// File: rtl/cfg_len_monitor.sv
`timescale 1ns/1ps
module cfg_len_monitor
  import cfg_len_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             cfgClk,
  input  logic             initReady,
  input  logic             lenLoad,
  input  logic [CNT_W-1:0] lenValue,
  input  logic             memFull,
  input  logic             expressMode,
  output logic             startPulse
);

  dpStrobe_t        strobe;
  dpFlags_t         flags;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] lenVal;
  logic             doneLatch;
  cfgMode_e         mode;

  assign mode = cfgMode_e'(expressMode);

  cfg_len_datapath #(.CNT_W(CNT_W)) uDp (
    .clk    (cfgClk),
    .clrN   (initReady),
    .strobe (strobe),
    .lenIn  (lenValue),
    .flags  (flags),
    .cntQ   (cntVal),
    .lenQ   (lenVal)
  );

  cfg_len_control uCtl (
    .clk       (cfgClk),
    .clrN      (initReady),
    .loadReq   (lenLoad),
    .fullFlag  (memFull),
    .mode      (mode),
    .flags     (flags),
    .strobe    (strobe),
    .doneLatch (doneLatch),
    .pulseQ    (startPulse)
  );

endmodule

// File: rtl/cfg_len_checker.sv
`timescale 1ns/1ps
module cfg_len_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             initReady,
  input logic             memFull,
  input logic             expressMode,
  input logic             startPulse,
  input logic             doneLatch,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] lenVal
);

  AST_INIT_CLEARS: assert property (@(posedge clk)
    !initReady |-> (!startPulse && cntVal == '0 && lenVal == '0 && !doneLatch)); // R6

  AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!initReady)
    startPulse |=> !startPulse); // R7

  AST_ONCE_PER_CONFIG: assert property (@(posedge clk) disable iff (!initReady)
    $past(doneLatch) |-> !startPulse); // R7

  AST_PULSE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!initReady)
    startPulse |-> $past(memFull)); // R3

  AST_COUNTED_EXACT: assert property (@(posedge clk) disable iff (!initReady)
    (startPulse && !$past(expressMode)) |->
      ($past(cntVal) == $past(lenVal) && $past(lenVal) != '0)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!initReady)
    ($past(initReady) && !$past(doneLatch)) |->
      (cntVal == $past(cntVal) + CNT_W'(1))); // R4

endmodule

bind cfg_len_monitor cfg_len_checker #(.CNT_W(CNT_W)) uChk (
  .clk         (cfgClk),
  .initReady   (initReady),
  .memFull     (memFull),
  .expressMode (expressMode),
  .startPulse  (startPulse),
  .doneLatch   (doneLatch),
  .cntVal      (cntVal),
  .lenVal      (lenVal)
);

// File: tb/sim_cfg_len_monitor.sv
`timescale 1ns/1ps
module sim_cfg_len_monitor;

  localparam int CNT_W = 8;
  localparam int WRAP  = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             initReady = 1'b0;
  logic             lenLoad = 1'b0;
  logic [CNT_W-1:0] lenValue = '0;
  logic             memFull = 1'b0;
  logic             expressMode = 1'b0;
  logic             startPulse;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  int expQ[$];
  string curTag = "";

  always #2.5 clk = ~clk;

  cfg_len_monitor #(.CNT_W(CNT_W)) u0 (
    .cfgClk      (clk),
    .initReady   (initReady),
    .lenLoad     (lenLoad),
    .lenValue    (lenValue),
    .memFull     (memFull),
    .expressMode (expressMode),
    .startPulse  (startPulse)
  );

  // bench's own count of edges since init rose
  always @(posedge clk) begin
    if (!initReady) edgeCnt <= 0;
    else            edgeCnt <= edgeCnt + 1;
  end

  // monitor: pop expected pulse edge and compare
  always @(negedge clk) begin
    if (startPulse) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected pulse at edge %0d, expected none", curTag, edgeCnt);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != edgeCnt) begin
          errors++;
          $display("FAIL %s: pulse at edge %0d, expected edge %0d", curTag, edgeCnt, e);
        end
      end
    end
  end

  // driver: lenA/lenB < 0 means no load, fullAt < 0 means never full
  task automatic runCase(input string tag, input int lenA, input int lenB,
                         input int fullAt, input bit expr, input int expectAt,
                         input int runFor);
    @(negedge clk);
    initReady = 1'b0; memFull = 1'b0; lenLoad = 1'b0; expressMode = expr;
    curTag = tag;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (startPulse !== 1'b0) begin
      errors++;
      $display("FAIL R6 %s: startPulse=%b with init low, expected 0", tag, startPulse);
    end
    if (expectAt >= 0) expQ.push_back(expectAt);
    initReady = 1'b1;
    while (edgeCnt < runFor) begin
      @(negedge clk);
      lenLoad = 1'b0;
      if (edgeCnt == 2 && lenA >= 0) begin lenLoad = 1'b1; lenValue = CNT_W'(lenA); end
      if (edgeCnt == 4 && lenB >= 0) begin lenLoad = 1'b1; lenValue = CNT_W'(lenB); end
      if (fullAt >= 0 && edgeCnt == fullAt - 1) memFull = 1'b1;
    end
    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: pulse missing, actual none, expected edge %0d", tag, expQ[0]);
      expQ.delete();
    end
  endtask

  initial begin
    // R2 R3 R7: early full, pulse at L+1, no repeat while full stays high
    runCase("R2 base",          20, -1, 10, 1'b0, 21, 60);
    // R1: second load replaces first
    runCase("R1 reload",        50, 30, 10, 1'b0, 31, 80);
    // R2 boundary: full arrives exactly at the matching edge
    runCase("R2 just in time",  15, -1, 16, 1'b0, 16, 40);
    // R4: full one edge late, recovered after wrap
    runCase("R4 one late",      15, -1, 17, 1'b0, 16 + WRAP, 16 + WRAP + 20);
    runCase("R4 far late",      15, -1, 30, 1'b0, 16 + WRAP, 16 + WRAP + 20);
    // R5: express ignores stored length
    runCase("R5 express",      200, -1, 40, 1'b1, 40, 80);
    runCase("R5 express noload", -1, -1, 7, 1'b1, 7, 30);
    // R8: zero length never matches, across two wraps
    runCase("R8 zero length",    0, -1,  5, 1'b0, -1, 2 * WRAP + 50);
    // R6: length cleared by init low, no load now means no completion
    runCase("R6 cleared length", -1, -1, 5, 1'b0, -1, WRAP + 50);
    // R3: count reached but memory never full
    runCase("R3 no full",       10, -1, -1, 1'b0, -1, WRAP + 50);
    // R6: counter restarted from zero after previous configs
    runCase("R6 restart",       25, -1,  3, 1'b0, 26, 60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule